// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Pointer

This block is an I2C target that runs entirely on the system clock. It oversamples the bus lines through two-flop synchronizers and works out START, repeated START and STOP conditions from the sampled levels. It answers to one fixed 7-bit device address. Behind the bus it holds a small byte-wide register file, reached through an internal pointer.

In a write, the first byte after the address byte sets the pointer. Each later byte is stored where the pointer points, and the pointer then steps forward. In a read, bytes come out starting at the current pointer, which steps forward after each byte. The read goes on until the controller answers a byte with a not-acknowledge. The pointer keeps its value from one transaction to the next, so a read with no pointer write first carries on from where the previous access stopped.

The block never drives SDA high. It only pulls SDA low, through an output enable, and the pad or bench supplies the pull-up.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA output enable is 0, the pointer is 0 and every register reads 0x00.
- R2: An address byte whose upper seven bits equal 1101000 is acknowledged: SDA is pulled low during the ninth clock. Bit 0 of that byte selects the direction, 0 for a write and 1 for a read.
- R3: An address byte with any other upper seven bits is not acknowledged. Bytes after it, up to the next START or STOP, get no acknowledge and change neither the registers nor the pointer.
- R4: In a write, the byte after the address byte is acknowledged, and its low six bits are loaded into the pointer. The upper two bits have no effect.
- R5: Each later byte of a write is acknowledged and stored at the pointer, and then the pointer increments. A write may carry zero data bytes.
- R6: Every byte is shifted most-significant bit first, in both directions.
- R7: In a read, the byte at the pointer is driven onto SDA and the pointer increments once per byte sent. Sending goes on while the controller acknowledges. After a not-acknowledge, SDA is left released until the next START.
- R8: A read that is not preceded by a pointer write starts at the pointer value left by the previous transaction.
- R9: The register file holds 64 bytes, and the pointer wraps from 63 to 0 on writes and on reads.
- R10: A repeated START ends the current transfer, and the next byte is decoded as a new address byte.
- R11: The SDA output enable changes only while SCL is low. Input bits are sampled on the rising edge of SCL.
- R12: A STOP (SDA rising while SCL is high) ends any transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The hardest case to reach is an address byte for another device, followed by bytes that would be a valid pointer and valid data if the block wrongly accepted them. To make this case observable, the stimulus first sets the pointer and some register contents. It then sends the foreign address with the trap bytes, and finally reads back with and without a pointer write. If the block had acted on the foreign transfer, the pointer would have moved or a register would hold the trap value, and the readback would show it. Wrap-around and pointer persistence are reached the same way: chains of transactions leave the pointer at 62, and it is then read across the 63-to-0 boundary through a repeated START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {2{RST_VAL[i]}};
      else        stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  // Conditions count only while SCL stays high across both samples.
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         DEPTH    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_tgt_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int BW    = 8;
  localparam int CNT_W = $clog2(BW + 1);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [1:0] bus_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_sync2 #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2c_cond_det u_det (
    .clk(clk), .rst_n(rst_int_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e       st, st_n;
  byte_kind_e       kind, kind_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [BW-2:0]    sh, sh_n;
  logic [BW-2:0]    tx, tx_n;
  logic             oe, oe_n;
  logic             rd, rd_n;
  logic             ackp, ackp_n;
  logic [PTR_W-1:0] ptr;
  logic             ptr_ld, ptr_inc, reg_we;
  logic [BW-1:0]    byte_w, rd_data;

  assign byte_w = {sh, sda_s};

  i2c_regfile #(.DEPTH(DEPTH), .DW(BW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(ptr),
    .wdata(byte_w), .rdata(rd_data)
  );

  always_comb begin
    st_n    = st;
    kind_n  = kind;
    cnt_n   = cnt;
    sh_n    = sh;
    tx_n    = tx;
    oe_n    = oe;
    rd_n    = rd;
    ackp_n  = ackp;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;
    reg_we  = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_RX;
      kind_n = BK_ADDR;
      cnt_n  = '0;
      oe_n   = 1'b0;
      rd_n   = 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = byte_w[BW-2:0];
            cnt_n = cnt + CNT_W'(1);
            if (cnt == CNT_W'(BW - 1)) begin
              unique case (kind)
                BK_ADDR: begin
                  ackp_n = (byte_w[BW-1:1] == DEV_ADDR);
                  rd_n   = byte_w[0];
                  kind_n = BK_PTR;
                end
                BK_PTR: begin
                  ackp_n = 1'b1;
                  ptr_ld = 1'b1;
                  kind_n = BK_DATA;
                end
                default: begin
                  ackp_n  = 1'b1;
                  reg_we  = 1'b1;
                  ptr_inc = 1'b1;
                end
              endcase
            end
          end else if (scl_fall && cnt == CNT_W'(BW)) begin
            cnt_n = '0;
            if (ackp) begin
              st_n = ST_RX_ACK;
              oe_n = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rd) begin
              st_n    = ST_TX;
              tx_n    = rd_data[BW-2:0];
              oe_n    = ~rd_data[BW-1];
              ptr_inc = 1'b1;
            end else begin
              st_n = ST_RX;
              oe_n = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt == CNT_W'(BW)) begin
              st_n  = ST_TX_ACK;
              oe_n  = 1'b0;
              cnt_n = '0;
            end else begin
              tx_n = {tx[BW-3:0], 1'b0};
              oe_n = ~tx[BW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) begin
            st_n = ST_IDLE;
          end else if (scl_fall) begin
            st_n    = ST_TX;
            cnt_n   = '0;
            tx_n    = rd_data[BW-2:0];
            oe_n    = ~rd_data[BW-1];
            ptr_inc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st   <= ST_IDLE;
      kind <= BK_ADDR;
      cnt  <= '0;
      sh   <= '0;
      tx   <= '0;
      oe   <= 1'b0;
      rd   <= 1'b0;
      ackp <= 1'b0;
    end else begin
      st   <= st_n;
      kind <= kind_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      tx   <= tx_n;
      oe   <= oe_n;
      rd   <= rd_n;
      ackp <= ackp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ptr <= '0;
    else if (ptr_ld)  ptr <= byte_w[PTR_W-1:0];
    else if (ptr_inc) ptr <= ptr + PTR_W'(1);
  end

  assign sda_oe = oe;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             start_det,
  input logic             stop_det,
  input tgt_state_e       st,
  input logic [PTR_W-1:0] ptr,
  input logic             ptr_ld
);
  // R11: the enable is raised only while the synchronized SCL is low
  p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: the enable is dropped only while the synchronized SCL is low
  p_oe_fall_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(sda_oe) |-> !scl_s);

  // R10: after a START the block releases SDA and decodes a new byte
  p_start_rx_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_det && !stop_det |=> st == ST_RX && !sda_oe);

  // R12: a STOP returns to idle with SDA released
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_det |=> st == ST_IDLE && !sda_oe);

  // R3: while idle the block never pulls SDA
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    st == ST_IDLE |-> !sda_oe);

  // R9: the pointer moves only by a load or a single wrapping step
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr != $past(ptr) |-> $past(ptr_ld) || ptr == $past(ptr) + PTR_W'(1));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .st(st), .ptr(ptr),
  .ptr_ld(ptr_ld)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 5;
  localparam int WDOG       = 100000;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic clk, rst_n, scl_c, sda_c;
  logic sda_oe;
  wire  sda_bus = sda_c & ~sda_oe;

  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int n_chk, n_fail, oe_viol;
  bit done;
  logic oe_prev;

  i2c_reg_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // R11: the enable must never move while the controller holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_c && sda_oe !== oe_prev) oe_viol++;
    oe_prev = sda_oe;
  end

  // Scoreboard monitor
  initial begin
    exp_t       e;
    logic [7:0] a;
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_chk++;
        if (a !== e.v) begin
          n_fail++;
          $display("FAIL %s actual=%02h expected=%02h", e.tag, a, e.v);
        end
      end
    end
  end

  task automatic expect_v(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; scl_c = 1'b1; qwait();
    sda_c = 1'b0; qwait();
    scl_c = 1'b0; qwait();
  endtask

  task automatic bus_rstart();
    sda_c = 1'b1; qwait();
    scl_c = 1'b1; qwait();
    sda_c = 1'b0; qwait();
    scl_c = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; qwait();
    scl_c = 1'b1; qwait();
    sda_c = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_c = b; qwait();
    scl_c = 1'b1; qwait(); qwait();
    scl_c = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_c = 1'b1; qwait();
    scl_c = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_c = 1'b0; qwait();
  endtask

  // Sends a byte MSB first; scores the acknowledge bit (0 = acknowledged).
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic ab;
    expect_v({7'd0, ~exp_ack}, tag);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(ab);
    act_q.push_back({7'd0, ab});
  endtask

  // Receives a byte MSB first, scores it, then answers ACK or NACK.
  task automatic recv_byte(input logic [7:0] exp_b, input bit give_ack, input string tag);
    logic [7:0] r;
    logic       b;
    expect_v(exp_b, tag);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      r[i] = b;
    end
    act_q.push_back(r);
    put_bit(~give_ack);
  endtask

  task automatic check_oe(input string tag);
    expect_v(8'h00, tag);
    act_q.push_back({7'd0, sda_oe});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic b;
    rst_n = 1'b0; scl_c = 1'b1; sda_c = 1'b1; oe_prev = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_oe("R1 reset enable");

    // R1/R2: read at reset pointer 0
    bus_start();
    send_byte(8'hD1, 1, "R2 read address ack");
    recv_byte(8'h00, 0, "R1 reset register value");
    bus_stop();

    // R4/R5: pointer byte 0xC5 selects 5; four data bytes
    bus_start();
    send_byte(8'hD0, 1, "R2 write address ack");
    send_byte(8'hC5, 1, "R4 pointer byte ack");
    send_byte(8'h12, 1, "R5 data ack");
    send_byte(8'hC7, 1, "R5 data ack");
    send_byte(8'h5E, 1, "R5 data ack");
    send_byte(8'h0F, 1, "R5 data ack");
    bus_stop();
    check_oe("R12 released after stop");

    // R4 zero-data write, then R6/R7 read
    bus_start();
    send_byte(8'hD0, 1, "R4 write address ack");
    send_byte(8'h05, 1, "R4 pointer ack");
    bus_stop();
    bus_start();
    send_byte(8'hD1, 1, "R7 read address ack");
    recv_byte(8'h12, 1, "R6 msb first");
    recv_byte(8'hC7, 1, "R7 second byte");
    recv_byte(8'h5E, 0, "R7 third byte");
    get_bit(b);
    expect_v(8'h01, "R7 released after nack");
    act_q.push_back({7'd0, b});
    bus_stop();

    // R8: resume from pointer 8
    bus_start();
    send_byte(8'hD1, 1, "R8 read address ack");
    recv_byte(8'h0F, 0, "R8 resumed pointer");
    bus_stop();

    // R9/R10: wrap across 63 and repeated start
    bus_start();
    send_byte(8'hD0, 1, "R9 write address ack");
    send_byte(8'h3E, 1, "R9 pointer 62 ack");
    send_byte(8'hA1, 1, "R9 data ack");
    send_byte(8'hB2, 1, "R9 data ack");
    send_byte(8'hC3, 1, "R9 data at wrapped 0 ack");
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, "R10 write address ack");
    send_byte(8'h3E, 1, "R10 pointer ack");
    bus_rstart();
    send_byte(8'hD1, 1, "R10 fresh address ack");
    recv_byte(8'hA1, 1, "R9 reg 62");
    recv_byte(8'hB2, 1, "R9 reg 63");
    recv_byte(8'hC3, 0, "R9 reg 0 after wrap");
    bus_stop();
    bus_start();
    send_byte(8'hD1, 1, "R9 read address ack");
    recv_byte(8'h00, 0, "R9 pointer at 1 after wrap");
    bus_stop();

    // R3: foreign addresses ignored
    bus_start();
    send_byte(8'hD0, 1, "R3 setup ack");
    send_byte(8'h0A, 1, "R3 setup pointer");
    send_byte(8'h77, 1, "R3 setup data");
    send_byte(8'h66, 1, "R3 setup data");
    send_byte(8'h55, 1, "R3 setup data");
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, "R3 setup ack");
    send_byte(8'h0B, 1, "R3 setup pointer 11");
    bus_stop();
    bus_start();
    send_byte(8'hA0, 0, "R3 foreign address nack");
    send_byte(8'h0A, 0, "R3 trap pointer nack");
    send_byte(8'h99, 0, "R3 trap data nack");
    bus_stop();
    bus_start();
    send_byte(8'hD3, 0, "R3 near-miss address nack");
    bus_stop();
    bus_start();
    send_byte(8'hD1, 1, "R3 read address ack");
    recv_byte(8'h66, 1, "R3 pointer unchanged");
    recv_byte(8'h55, 0, "R3 next byte");
    bus_stop();
    bus_start();
    send_byte(8'hD0, 1, "R3 write address ack");
    send_byte(8'h0A, 1, "R3 pointer 10");
    bus_rstart();
    send_byte(8'hD1, 1, "R10 read after rstart ack");
    recv_byte(8'h77, 0, "R3 register not overwritten");
    bus_stop();
    check_oe("R12 final release");

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard R7 actual=%0d expected=%0d", act_q.size(), exp_q.size());
    end
    n_chk++;
    if (oe_viol != 0) begin
      n_fail++;
      $display("FAIL R11 enable moved with SCL high actual=%0d expected=0", oe_viol);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule